// File: doc/BRIEF.md
# Trigger-Timed ADC Sampling Scheduler

This block decides when each of up to 24 programmed sampling events is handed to one of two ADC interfaces. Two event timers count ADC-clock ticks. Each timer is started by a rising edge on one trigger line, picked from a small set of inputs such as a PWM sync pulse. Every event carries its own settings:

- an enable
- the timer it belongs to
- the interface it goes to
- an 8-bit channel control word
- a memory offset
- a flag that asks for simultaneous sampling
- an event time, counted in ticks after its timer starts

When a running timer's count equals an enabled event's time, the event is matched. The match places the event in the pending queue of its interface. That queue is eight entries deep.

A sequencer for each interface takes the head of its queue. It raises a request that carries the control word, the offset and the event number, and holds it until the ADC side returns a done pulse. The serial conversion and the memory write are outside the block. A timer stops once every enabled event bound to it has been completed or dropped, and it then sets its frame-complete flag. Status is six sticky bits, cleared by a write-one-to-clear input:

| Bit | Meaning |
|---|---|
| 0 | frame complete, timer 0 |
| 1 | frame complete, timer 1 |
| 2 | trigger overrun, timer 0 |
| 3 | trigger overrun, timer 1 |
| 4 | event collision |
| 5 | event miss |

Each timer has a two-state machine:

| From | Condition | To |
|---|---|---|
| T_IDLE | accepted trigger edge | T_RUN |
| T_RUN | remaining count reaches zero | T_IDLE |

Each interface sequencer has a three-state machine:

| From | Condition | To |
|---|---|---|
| S_IDLE | queue head is ordinary | S_BUSY |
| S_IDLE | queue head is flagged simultaneous | S_PAIR |
| S_PAIR | other sequencer is also in S_PAIR (both leave on the same edge) | S_BUSY |
| S_BUSY | done pulse | S_IDLE |

Top module: `adc_evt_sched`

## Requirements
- R1: A timer starts only on a rising edge of the trigger input chosen by its 2-bit select field (timer 0 uses bits 1:0 of `trig_sel`, timer 1 uses bits 3:2). Once started, its count advances by one on each cycle with `aclk_tick` high. Edges on other trigger inputs have no effect.
- R2: An enabled event is matched once, when its timer's count equals its event time. Two events with times T0 and T1 on a free interface have their requests rise (T1−T0) ticks apart.
- R3: While an interface request is high, it presents the event's control word, offset and event number. It stays high until a done pulse arrives for that interface.
- R4: Each interface owns an 8-entry pending queue. Its requests are issued in match order, and within one cycle the lower event index comes first.
- R5: A timer stops and sets its frame-complete bit (bit 0 for timer 0, bit 1 for timer 1) once every enabled event bound to it has been completed or dropped.
- R6: A trigger edge for a timer that is running, or whose frame-complete bit is still set, is ignored and sets the overrun bit (bit 2 for timer 0, bit 3 for timer 1).
- R7: An event matched while its interface is busy or its queue is non-empty sets the collision bit, bit 4.
- R8: A simultaneous-flagged event waits at its queue head until the other interface also holds a simultaneous-flagged head. Both requests then rise in the same cycle.
- R9: A matched event is dropped and sets the miss bit, bit 5, when its queue is full or when a lower-index event matched for the same interface in the same cycle. A dropped event counts as handled for its frame.
- R10: The status bits reset to zero, stay set until cleared, and each `stat_clr` bit clears the status bit at the same position.
- R11: A disabled event is never issued and is not counted toward its timer's frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| aclk_tick | input | 1 | one-cycle strobe, one per ADC-clock period |
| trig_in | input | NUM_TRIG | trigger candidate lines |
| trig_sel | input | 2*SEL_W | trigger select for each timer |
| evt_en | input | NUM_EVT | event enables |
| evt_tmr | input | NUM_EVT | timer binding of each event |
| evt_if | input | NUM_EVT | interface binding of each event |
| evt_sim | input | NUM_EVT | simultaneous-sampling flags |
| evt_ctl | input | NUM_EVT*8 | channel control words |
| evt_ofs | input | NUM_EVT*8 | memory offsets |
| evt_time | input | NUM_EVT*TIME_W | event times in ticks |
| if_req | output | 2 | request per interface |
| if_ctl | output | 16 | control word per interface |
| if_ofs | output | 16 | offset per interface |
| if_evt | output | 10 | event number per interface |
| if_done | input | 2 | completion pulse per interface |
| stat | output | 6 | sticky status bits |
| stat_clr | input | 6 | write-one-to-clear strobes |

## Verification
The assertions rely on four assumptions about the inputs:

- A done pulse arrives only while the matching request is high.
- Simultaneous-flagged events are configured in pairs, one on each interface.
- The event table is not changed while a timer runs.
- Within a frame, a timer's count never wraps before all its events have matched.

The bench honours these assumptions. Its responders answer only a raised request, after a programmed latency. It reconfigures the table only between frames, with both timers idle. Every simultaneous event it programs has a partner with the same time on the other interface.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;
    localparam int CTL_W = 8;
    localparam int OFS_W = 8;
    localparam int ID_W  = 5;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic             tmr;
        logic             sim;
        logic [CTL_W-1:0] ctl;
        logic [OFS_W-1:0] ofs;
    } slot_t;

    localparam int SLOT_W = $bits(slot_t);

    localparam int B_FRM0 = 0;
    localparam int B_OVR0 = 2;
    localparam int B_COL  = 4;
    localparam int B_MISS = 5;
endpackage

// File: rtl/sched_fifo.sv
module sched_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   fill;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            fill <= fill + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
        end
    end

    assign dout  = mem[rp];
    assign empty = (fill == '0);
    assign full  = (fill == (AW+1)'(DEPTH));

    AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R4
    AST_POP_DATA: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R4
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
    parameter int TIME_W = 12,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic [CNT_W-1:0]  load,
    input  logic [CNT_W-1:0]  dec,
    output logic              running,
    output logic [TIME_W-1:0] cnt,
    output logic              fresh,
    output logic              fin
);
    typedef enum logic {T_IDLE, T_RUN} tst_t;
    tst_t st, st_n;
    logic [CNT_W-1:0] rem, rem_n;

    assign rem_n = rem - dec;

    always_comb begin
        st_n = st;
        unique case (st)
            T_IDLE: if (start) st_n = T_RUN;
            T_RUN:  if (rem_n == '0) st_n = T_IDLE;
            default: st_n = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= T_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            fresh <= 1'b0;
            rem   <= '0;
        end else begin
            fresh <= 1'b0;
            if (st == T_IDLE) begin
                if (start) begin
                    cnt   <= '0;
                    fresh <= 1'b1;
                    rem   <= load;
                end
            end else begin
                rem <= rem_n;
                if (tick) begin
                    cnt   <= cnt + 1'b1;
                    fresh <= 1'b1;
                end
            end
        end
    end

    assign running = (st == T_RUN);
    assign fin     = running && (rem_n == '0);

    AST_TIMER_HALTS: assert property (@(posedge clk) disable iff (!rst_n) fin |=> !running); // R5
    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (start && !running) |=> (running && cnt == '0)); // R1
endmodule

// File: rtl/if_seq.sv
module if_seq
    import adc_sched_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t head,
    input  logic  empty,
    input  logic  peer_pair,
    input  logic  done,
    output logic  pop,
    output logic  req,
    output logic  in_pair,
    output logic  idle,
    output slot_t cur,
    output logic  fin,
    output logic  fin_tmr
);
    typedef enum logic [1:0] {S_IDLE, S_PAIR, S_BUSY} sst_t;
    sst_t st, st_n;

    always_comb begin
        st_n = st;
        pop  = 1'b0;
        unique case (st)
            S_IDLE: if (!empty) begin
                if (head.sim) st_n = S_PAIR;
                else begin
                    st_n = S_BUSY;
                    pop  = 1'b1;
                end
            end
            S_PAIR: if (peer_pair) begin
                st_n = S_BUSY;
                pop  = 1'b1;
            end
            S_BUSY: if (done) st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cur <= '0;
        else if (pop) cur <= head;
    end

    always_comb begin
        req     = (st == S_BUSY);
        in_pair = (st == S_PAIR);
        idle    = (st == S_IDLE);
        fin     = req && done;
        fin_tmr = cur.tmr;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (req && !done) |=> (req && $stable(cur))); // R3
endmodule

// File: rtl/adc_evt_sched.sv
module adc_evt_sched
    import adc_sched_pkg::*;
#(
    parameter int NUM_EVT    = 24,
    parameter int TIME_W     = 12,
    parameter int NUM_TRIG   = 4,
    parameter int FIFO_DEPTH = 8,
    localparam int SEL_W     = $clog2(NUM_TRIG),
    localparam int CNT_W     = $clog2(NUM_EVT + 3)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      aclk_tick,
    input  logic [NUM_TRIG-1:0]       trig_in,
    input  logic [2*SEL_W-1:0]        trig_sel,
    input  logic [NUM_EVT-1:0]        evt_en,
    input  logic [NUM_EVT-1:0]        evt_tmr,
    input  logic [NUM_EVT-1:0]        evt_if,
    input  logic [NUM_EVT-1:0]        evt_sim,
    input  logic [NUM_EVT*CTL_W-1:0]  evt_ctl,
    input  logic [NUM_EVT*OFS_W-1:0]  evt_ofs,
    input  logic [NUM_EVT*TIME_W-1:0] evt_time,
    output logic [1:0]                if_req,
    output logic [2*CTL_W-1:0]        if_ctl,
    output logic [2*OFS_W-1:0]        if_ofs,
    output logic [2*ID_W-1:0]         if_evt,
    input  logic [1:0]                if_done,
    output logic [5:0]                stat,
    input  logic [5:0]                stat_clr
);
    logic [NUM_TRIG-1:0] trig_q;
    logic [1:0] edge_hit, start, run, fresh, tfin, ovr;
    logic [TIME_W-1:0] tcnt [2];
    logic [CNT_W-1:0]  ld [2];
    logic [CNT_W-1:0]  dec [2];
    logic [CNT_W-1:0]  mcnt [2];

    logic [1:0] push, pop, empty, full, pair, idle, ifin, ifin_tmr;
    slot_t ent [2];
    slot_t head [2];
    slot_t cur [2];
    logic [SLOT_W-1:0] fdout [2];
    logic miss_hit, col_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= '0;
        else        trig_q <= trig_in;
    end

    // Per-timer frame size: enabled events bound to that timer
    always_comb begin
        for (int t = 0; t < 2; t++) begin
            ld[t] = '0;
            for (int e = 0; e < NUM_EVT; e++)
                if (evt_en[e] && (evt_tmr[e] == 1'(t))) ld[t] = ld[t] + 1'b1;
        end
    end

    // Match every event against its timer; one push per interface per cycle
    always_comb begin
        logic tm, ii;
        tm       = 1'b0;
        ii       = 1'b0;
        push     = '0;
        miss_hit = 1'b0;
        for (int i = 0; i < 2; i++) begin
            ent[i]  = '0;
            mcnt[i] = '0;
        end
        for (int e = 0; e < NUM_EVT; e++) begin
            tm = evt_tmr[e];
            ii = evt_if[e];
            if (evt_en[e] && run[tm] && fresh[tm] &&
                (tcnt[tm] == evt_time[e*TIME_W +: TIME_W])) begin
                if (!push[ii] && !full[ii]) begin
                    push[ii]    = 1'b1;
                    ent[ii].id  = ID_W'(e);
                    ent[ii].tmr = tm;
                    ent[ii].sim = evt_sim[e];
                    ent[ii].ctl = evt_ctl[e*CTL_W +: CTL_W];
                    ent[ii].ofs = evt_ofs[e*OFS_W +: OFS_W];
                end else begin
                    miss_hit = 1'b1;
                    mcnt[tm] = mcnt[tm] + 1'b1;
                end
            end
        end
    end

    assign col_hit = |(push & (~idle | ~empty));

    for (genvar t = 0; t < 2; t++) begin : g_tmr
        assign edge_hit[t] = trig_in[trig_sel[t*SEL_W +: SEL_W]] & ~trig_q[trig_sel[t*SEL_W +: SEL_W]];
        assign ovr[t]      = edge_hit[t] & (run[t] | stat[B_FRM0+t]);
        assign start[t]    = edge_hit[t] & ~ovr[t];
        assign dec[t]      = mcnt[t]
                           + CNT_W'(ifin[0] && (ifin_tmr[0] == 1'(t)))
                           + CNT_W'(ifin[1] && (ifin_tmr[1] == 1'(t)));

        evt_timer #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_tmr (
            .clk(clk), .rst_n(rst_n), .start(start[t]), .tick(aclk_tick),
            .load(ld[t]), .dec(dec[t]), .running(run[t]), .cnt(tcnt[t]),
            .fresh(fresh[t]), .fin(tfin[t])
        );

        AST_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (edge_hit[t] && run[t]) |=> stat[B_OVR0+t]); // R6
    end

    for (genvar i = 0; i < 2; i++) begin : g_if
        sched_fifo #(.DEPTH(FIFO_DEPTH), .W(SLOT_W)) u_q (
            .clk(clk), .rst_n(rst_n), .push(push[i]), .din(ent[i]),
            .pop(pop[i]), .dout(fdout[i]), .empty(empty[i]), .full(full[i])
        );
        assign head[i] = fdout[i];

        if_seq u_seq (
            .clk(clk), .rst_n(rst_n), .head(head[i]), .empty(empty[i]),
            .peer_pair(pair[1-i]), .done(if_done[i]), .pop(pop[i]),
            .req(if_req[i]), .in_pair(pair[i]), .idle(idle[i]), .cur(cur[i]),
            .fin(ifin[i]), .fin_tmr(ifin_tmr[i])
        );

        assign if_ctl[i*CTL_W +: CTL_W] = cur[i].ctl;
        assign if_ofs[i*OFS_W +: OFS_W] = cur[i].ofs;
        assign if_evt[i*ID_W +: ID_W]   = cur[i].id;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~stat_clr) | {miss_hit, col_hit, ovr, tfin};
    end

    AST_SIM_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n) ($rose(if_req[0]) && cur[0].sim) |-> $rose(if_req[1])); // R8
    AST_MISS_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n) (|(full & ~pop) && miss_hit) |=> stat[B_MISS]); // R9
    AST_COL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (stat[B_COL] && !stat_clr[B_COL]) |=> stat[B_COL]); // R10
endmodule

// File: tb/sim_adc_evt_sched.sv
`timescale 1ns/1ps
module sim_adc_evt_sched;
    localparam int NE = 24;
    localparam int TW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic aclk_tick = 1'b1;
    logic [3:0] trig_in = '0;
    logic [3:0] trig_sel = {2'd2, 2'd1};
    logic [NE-1:0] evt_en = '0, evt_tmr = '0, evt_if = '0, evt_sim = '0;
    logic [NE*8-1:0] evt_ctl = '0, evt_ofs = '0;
    logic [NE*TW-1:0] evt_time = '0;
    logic [1:0] if_req;
    logic [15:0] if_ctl, if_ofs;
    logic [9:0] if_evt;
    logic [1:0] if_done = '0;
    logic [5:0] stat;
    logic [5:0] stat_clr = '0;

    int n_chk = 0, n_err = 0, cyc = 0, tdiv = 1, tph = 0;
    int lat [2] = '{1, 1};
    int wcnt [2] = '{0, 0};
    int n_log [2] = '{0, 0};
    int log_id [2][64];
    int log_cyc [2][64];
    int log_ctl [2][64];
    bit done_all = 0;

    adc_evt_sched u0 (
        .clk(clk), .rst_n(rst_n), .aclk_tick(aclk_tick), .trig_in(trig_in),
        .trig_sel(trig_sel), .evt_en(evt_en), .evt_tmr(evt_tmr), .evt_if(evt_if),
        .evt_sim(evt_sim), .evt_ctl(evt_ctl), .evt_ofs(evt_ofs), .evt_time(evt_time),
        .if_req(if_req), .if_ctl(if_ctl), .if_ofs(if_ofs), .if_evt(if_evt),
        .if_done(if_done), .stat(stat), .stat_clr(stat_clr)
    );

    always #2.5 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    initial forever begin
        @(negedge clk);
        if (tdiv <= 1) aclk_tick = 1'b1;
        else begin
            tph = (tph + 1) % tdiv;
            aclk_tick = (tph == 0);
        end
    end

    // ADC-side responders: log each request, answer after lat cycles
    initial forever begin
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            if (if_done[i]) begin
                if_done[i] = 1'b0;
                wcnt[i] = 0;
            end else if (if_req[i]) begin
                if (wcnt[i] == 0 && n_log[i] < 64) begin
                    log_id[i][n_log[i]]  = int'(if_evt[i*5 +: 5]);
                    log_ctl[i][n_log[i]] = int'(if_ctl[i*8 +: 8]);
                    log_cyc[i][n_log[i]] = cyc;
                    n_log[i]++;
                end
                if (wcnt[i] >= lat[i]) if_done[i] = 1'b1;
                else wcnt[i]++;
            end
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic clr_evts;
        evt_en = '0; evt_tmr = '0; evt_if = '0; evt_sim = '0;
        evt_ctl = '0; evt_ofs = '0; evt_time = '0;
    endtask

    task automatic set_evt(input int e, input bit en, input bit tm, input bit ifc,
                           input bit sim, input logic [7:0] ctl, input logic [TW-1:0] t);
        evt_en[e] = en; evt_tmr[e] = tm; evt_if[e] = ifc; evt_sim[e] = sim;
        evt_ctl[e*8 +: 8] = ctl; evt_ofs[e*8 +: 8] = ~ctl; evt_time[e*TW +: TW] = t;
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        trig_in[n] = 1'b1;
        @(negedge clk);
        trig_in[n] = 1'b0;
    endtask

    task automatic clear(input logic [5:0] v);
        @(negedge clk);
        stat_clr = v;
        @(negedge clk);
        stat_clr = '0;
    endtask

    task automatic wait_bit(input int b, input int lim, input string rq);
        int k;
        k = 0;
        while (!stat[b] && k < lim) begin
            @(negedge clk);
            k++;
        end
        chk(rq, int'(stat[b]), 1);
    endtask

    task automatic t_reset;
        chk("R10 reset status", int'(stat), 0);
        chk("R3 reset requests", int'(if_req), 0);
    endtask

    task automatic t_basic;
        int b0, b1;
        clr_evts(); lat = '{1, 1}; tdiv = 1;
        set_evt(0, 1, 0, 0, 0, 8'h11, 0);
        set_evt(1, 1, 0, 0, 0, 8'h22, 5);
        set_evt(5, 0, 0, 1, 0, 8'h55, 0);
        b0 = n_log[0]; b1 = n_log[1];
        pulse(1);
        wait_bit(0, 200, "R5 frame bit timer0");
        chk("R4 request count if0", n_log[0] - b0, 2);
        chk("R2 first event id", log_id[0][b0], 0);
        chk("R4 second event id", log_id[0][b0+1], 1);
        chk("R3 first control word", log_ctl[0][b0], 8'h11);
        chk("R3 second control word", log_ctl[0][b0+1], 8'h22);
        chk("R2 issue spacing", log_cyc[0][b0+1] - log_cyc[0][b0], 5);
        chk("R11 disabled event not issued", n_log[1] - b1, 0);
        chk("R7 no collision", int'(stat[4]), 0);
        chk("R9 no miss", int'(stat[5]), 0);
        clear(6'b000001);
        chk("R10 bit0 cleared", int'(stat), 0);
    endtask

    task automatic t_ticks;
        int b0;
        clr_evts(); lat = '{1, 1}; tdiv = 3;
        set_evt(0, 1, 0, 0, 0, 8'h01, 2);
        set_evt(1, 1, 0, 0, 0, 8'h02, 7);
        b0 = n_log[0];
        pulse(3);
        idle_cycles(40);
        chk("R1 unselected trigger ignored", n_log[0] - b0, 0);
        pulse(1);
        wait_bit(0, 400, "R5 frame bit tick mode");
        chk("R1 request count", n_log[0] - b0, 2);
        chk("R1 spacing in ticks", log_cyc[0][b0+1] - log_cyc[0][b0], 15);
        clear(6'b111111);
        tdiv = 1;
    endtask

    task automatic t_pair;
        int b0, b1, k;
        clr_evts(); lat = '{8, 0};
        set_evt(4, 1, 1, 0, 0, 8'h44, 0);
        set_evt(2, 1, 1, 0, 1, 8'h2A, 3);
        set_evt(3, 1, 1, 1, 1, 8'h3B, 3);
        b0 = n_log[0]; b1 = n_log[1];
        pulse(2);
        k = 0;
        while (!if_req[0] && k < 50) begin
            @(negedge clk);
            k++;
        end
        pulse(2);
        wait_bit(1, 300, "R5 frame bit timer1");
        chk("R6 overrun while running", int'(stat[3]), 1);
        chk("R7 collision on busy interface", int'(stat[4]), 1);
        chk("R4 if0 first id", log_id[0][b0], 4);
        chk("R4 if0 second id", log_id[0][b0+1], 2);
        chk("R8 if1 id", log_id[1][b1], 3);
        chk("R8 pair issued together", log_cyc[0][b0+1], log_cyc[1][b1]);
        chk("R6 no extra frame if0", n_log[0] - b0, 2);
    endtask

    task automatic t_stale;
        int s0, s1;
        clear(6'b111100);
        chk("R10 selective clear", int'(stat), 6'b000010);
        s0 = n_log[0]; s1 = n_log[1];
        pulse(2);
        idle_cycles(2);
        chk("R6 overrun with flag set", int'(stat[3]), 1);
        idle_cycles(30);
        chk("R6 trigger ignored", (n_log[0] - s0) + (n_log[1] - s1), 0);
        clear(6'b111111);
    endtask

    task automatic t_full;
        int b0;
        clr_evts(); lat = '{40, 0}; tdiv = 1;
        for (int e = 0; e < 10; e++) set_evt(e, 1, 0, 0, 0, 8'(8'h60 + e), TW'(e));
        b0 = n_log[0];
        pulse(1);
        wait_bit(0, 1000, "R9 frame completes with drop");
        chk("R9 miss flagged", int'(stat[5]), 1);
        chk("R9 issued count", n_log[0] - b0, 9);
        for (int k = 0; k < 9; k++) chk("R4 queue order", log_id[0][b0+k], k);
        clear(6'b111111);
    endtask

    initial begin
        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(2);
        t_reset();
        t_basic();
        t_ticks();
        t_pair();
        t_stale();
        t_full();
        if (!done_all) begin
            done_all = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done_all) begin
            done_all = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule